// File: doc/BRIEF.md
# Banked Window Address Translator

This block sits between a 16-bit CPU core and its memory system. For every access it does two things. It turns the 16-bit logical address into a wider physical address through a paged bank window. It also decides which of four memory regions answers the access. Inside the window, the window offset is added to the page number shifted by a programmable amount and to a virtual base. Outside the window, the address passes through unchanged.

Region selection always uses the logical address and a strict overlay priority: I/O registers, then EEPROM, then NVRAM (internal RAM), then external RAM. An 8-bit relocation register positions the I/O block and the internal RAM at run time. The EEPROM and external RAM windows are fixed by parameters. An access that no region claims raises a miss strobe. All results leave through one register stage.

Top module: `banked_window_xlate`

## Requirements
- R1: When `win_start <= log_addr < win_end`, `phys_addr` = (`log_addr` − `win_start`) + (`page` << `bank_shift`) + `virt_base`, truncated to PA_W bits (default 24).
- R2: The window is half-open: an address equal to `win_start` is translated, and an address equal to `win_end` is not.
- R3: Outside the window, `phys_addr` equals `log_addr` zero-extended to PA_W bits.
- R4: `region_sel` is one-hot, decoded from `log_addr`: bit 0 I/O, bit 1 EEPROM, bit 2 NVRAM, bit 3 external RAM. Priority runs I/O > EEPROM > NVRAM > external RAM, and only the highest-priority matching region is selected.
- R5: The I/O block starts at relocation bits [3:0] << 12. It spans 64 bytes when IO_WIDE=0 and 1024 bytes when IO_WIDE=1.
- R6: The NVRAM block starts at relocation bits [7:4] << 8 and spans NVR_SIZE bytes (default 256).
- R7: EEPROM covers [EEP_BASE, EEP_BASE+EEP_SIZE), default 0xF000..0xF7FF. External RAM covers [EXT_BASE, EXT_BASE+EXT_SIZE), default 0x0000..0x7FFF.
- R8: When no region claims a valid access, `miss` is 1 and `region_sel` is 0. `miss` is 0 otherwise and in idle cycles.
- R9: The relocation register resets to 0x01. A write through `reloc_we`/`reloc_wdata` applies to accesses presented in later cycles. An access presented in the same cycle as the write still uses the old value.
- R10: Results appear one clock after `req_valid`, together with `out_valid`. In a cycle without `req_valid`, `out_valid` falls and `phys_addr` and `region_sel` hold their last values.
- R11: Synchronous reset clears `phys_addr`, `region_sel`, `miss` and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reloc_we | input | 1 | Relocation register write enable |
| reloc_wdata | input | 8 | Relocation register write data |
| req_valid | input | 1 | Access presented this cycle |
| log_addr | input | 16 | Logical CPU address |
| page | input | PAGE_W | Current bank page number |
| win_start | input | 16 | First address of the bank window |
| win_end | input | 16 | First address past the bank window |
| virt_base | input | PA_W | Physical base added to windowed accesses |
| bank_shift | input | SHIFT_W | Left shift applied to the page number |
| phys_addr | output | PA_W | Registered physical address |
| region_sel | output | 4 | Registered one-hot region select |
| miss | output | 1 | No region claimed the access |
| out_valid | output | 1 | Registered results are valid |

## Verification
The bench probes both ends of the window. A closed interval would translate `win_end`, and an off-by-one start would pass `win_start` through untranslated. It also makes the window sum overflow 24 bits, where a design without truncation would show the wrong low bits. Overlaps are set up with I/O over EEPROM and I/O over NVRAM, and also with internal regions over external RAM. A wrong priority would either raise two select bits or select the lower region. The first byte past each region end is checked, including the 64- and 1024-byte I/O spans on two instances. The bench also writes the relocation register in the same cycle as an access. A design that forwards the new value would switch regions one access too early.

// File: rtl/bxw_pkg.sv
package bxw_pkg;

  localparam int N_REGIONS = 4;

  typedef enum logic [1:0] {
    RG_IO  = 2'd0,
    RG_EEP = 2'd1,
    RG_NVR = 2'd2,
    RG_EXT = 2'd3
  } region_e;

  // Half-open range test on a 16-bit address, 17-bit arithmetic so that a
  // region touching the top of memory does not wrap.
  function automatic logic in_span(input logic [15:0] a,
                                   input logic [16:0] base,
                                   input logic [16:0] size);
    logic [16:0] ext;
    ext = {1'b0, a};
    return (ext >= base) && (ext < (base + size));
  endfunction

endpackage

// File: rtl/bxw_reloc_reg.sv
module bxw_reloc_reg #(
  parameter int          W         = 8,
  parameter logic [7:0]  RESET_VAL = 8'h01
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= W'(RESET_VAL);
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/bxw_window.sv
module bxw_window #(
  parameter int PA_W    = 24,
  parameter int PAGE_W  = 8,
  parameter int SHIFT_W = 5
) (
  input  logic [15:0]        addr,
  input  logic [PAGE_W-1:0]  page,
  input  logic [15:0]        win_start,
  input  logic [15:0]        win_end,
  input  logic [PA_W-1:0]    virt_base,
  input  logic [SHIFT_W-1:0] bank_shift,
  output logic               in_win,
  output logic [PA_W-1:0]    phys
);
  logic [15:0]     offset;
  logic [PA_W-1:0] page_term;
  logic [PA_W-1:0] mapped;

  always_comb begin
    in_win    = (addr >= win_start) && (addr < win_end);
    offset    = addr - win_start;
    page_term = PA_W'(page) << bank_shift;
    mapped    = PA_W'(offset) + page_term + virt_base;
    phys      = in_win ? mapped : PA_W'(addr);
  end
endmodule

// File: rtl/bxw_region_decode.sv
module bxw_region_decode
  import bxw_pkg::*;
#(
  parameter bit          IO_WIDE  = 1'b0,
  parameter int          EEP_BASE = 'hF000,
  parameter int          EEP_SIZE = 2048,
  parameter int          NVR_SIZE = 256,
  parameter int          EXT_BASE = 'h0000,
  parameter int          EXT_SIZE = 'h8000
) (
  input  logic [15:0]          addr,
  input  logic [7:0]           reloc,
  output logic [N_REGIONS-1:0] sel,
  output logic                 none
);
  localparam int IO_SPAN = IO_WIDE ? 1024 : 64;
  localparam int IO_AW   = $clog2(IO_SPAN);

  logic [15:0]          io_base;
  logic [15:0]          nvr_base;
  logic [N_REGIONS-1:0] hit;

  assign io_base  = {reloc[3:0], 12'h000};
  assign nvr_base = {4'h0, reloc[7:4], 8'h00};

  // I/O block is 4K aligned, so a compare of the bits above the span suffices.
  generate
    if (IO_WIDE) begin : g_io_wide
      assign hit[RG_IO] = (addr[15:IO_AW] == io_base[15:IO_AW]);
    end else begin : g_io_narrow
      assign hit[RG_IO] = (addr[15:IO_AW] == io_base[15:IO_AW]);
    end
  endgenerate

  assign hit[RG_EEP] = in_span(addr, 17'(EEP_BASE), 17'(EEP_SIZE));
  assign hit[RG_NVR] = in_span(addr, {1'b0, nvr_base}, 17'(NVR_SIZE));
  assign hit[RG_EXT] = in_span(addr, 17'(EXT_BASE), 17'(EXT_SIZE));

  // Lowest index wins.
  always_comb begin
    logic claimed;
    claimed = 1'b0;
    sel     = '0;
    for (int i = 0; i < N_REGIONS; i++) begin
      sel[i]  = hit[i] & ~claimed;
      claimed = claimed | hit[i];
    end
    none = ~claimed;
  end
endmodule

// File: rtl/banked_window_xlate.sv
module banked_window_xlate
  import bxw_pkg::*;
#(
  parameter int         PA_W      = 24,
  parameter int         PAGE_W    = 8,
  parameter int         SHIFT_W   = 5,
  parameter bit         IO_WIDE   = 1'b0,
  parameter int         EEP_BASE  = 'hF000,
  parameter int         EEP_SIZE  = 2048,
  parameter int         NVR_SIZE  = 256,
  parameter int         EXT_BASE  = 'h0000,
  parameter int         EXT_SIZE  = 'h8000,
  parameter logic [7:0] RELOC_RST = 8'h01
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reloc_we,
  input  logic [7:0]         reloc_wdata,
  input  logic               req_valid,
  input  logic [15:0]        log_addr,
  input  logic [PAGE_W-1:0]  page,
  input  logic [15:0]        win_start,
  input  logic [15:0]        win_end,
  input  logic [PA_W-1:0]    virt_base,
  input  logic [SHIFT_W-1:0] bank_shift,
  output logic [PA_W-1:0]    phys_addr,
  output logic [3:0]         region_sel,
  output logic               miss,
  output logic               out_valid
);
  logic [7:0]           reloc_q;
  logic                 in_win;
  logic [PA_W-1:0]      phys_c;
  logic [N_REGIONS-1:0] sel_c;
  logic                 none_c;

  bxw_reloc_reg #(.W(8), .RESET_VAL(RELOC_RST)) u_reloc (
    .clk(clk), .rst(rst), .we(reloc_we), .wdata(reloc_wdata), .q(reloc_q)
  );

  bxw_window #(.PA_W(PA_W), .PAGE_W(PAGE_W), .SHIFT_W(SHIFT_W)) u_win (
    .addr(log_addr), .page(page), .win_start(win_start), .win_end(win_end),
    .virt_base(virt_base), .bank_shift(bank_shift),
    .in_win(in_win), .phys(phys_c)
  );

  bxw_region_decode #(
    .IO_WIDE(IO_WIDE), .EEP_BASE(EEP_BASE), .EEP_SIZE(EEP_SIZE),
    .NVR_SIZE(NVR_SIZE), .EXT_BASE(EXT_BASE), .EXT_SIZE(EXT_SIZE)
  ) u_dec (
    .addr(log_addr), .reloc(reloc_q), .sel(sel_c), .none(none_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr  <= '0;
      region_sel <= '0;
      miss       <= 1'b0;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= req_valid;
      miss      <= req_valid & none_c;
      if (req_valid) begin
        phys_addr  <= phys_c;
        region_sel <= sel_c;
      end
    end
  end

  logic unused_ok;
  assign unused_ok = in_win;
endmodule

// File: rtl/bxw_checker.sv
module bxw_checker #(
  parameter int PA_W = 24
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [15:0]     log_addr,
  input logic [15:0]     win_start,
  input logic [15:0]     win_end,
  input logic [PA_W-1:0] phys_addr,
  input logic [3:0]      region_sel,
  input logic            miss,
  input logic            out_valid
);
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && !miss && $stable(phys_addr) && $stable(region_sel)));

  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(region_sel));

  assert_miss_matches_sel_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (miss == (region_sel == 4'b0000)));

  assert_passthrough_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !((log_addr >= win_start) && (log_addr < win_end)))
      |=> (phys_addr == PA_W'($past(log_addr))));

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (!out_valid && !miss && region_sel == 4'b0000));
endmodule

bind banked_window_xlate bxw_checker #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .log_addr(log_addr),
  .win_start(win_start), .win_end(win_end), .phys_addr(phys_addr),
  .region_sel(region_sel), .miss(miss), .out_valid(out_valid)
);

// File: tb/banked_window_xlate_tb.sv
module banked_window_xlate_tb;
  localparam int CLK_P = 10;
  localparam int PA_W  = 24;

  localparam logic [3:0] S_IO  = 4'b0001;
  localparam logic [3:0] S_EEP = 4'b0010;
  localparam logic [3:0] S_NVR = 4'b0100;
  localparam logic [3:0] S_EXT = 4'b1000;
  localparam logic [3:0] S_NONE = 4'b0000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reloc_we = 1'b0;
  logic [7:0]      reloc_wdata = 8'h00;
  logic            req_valid = 1'b0;
  logic [15:0]     log_addr = 16'h0;
  logic [7:0]      page = 8'h0;
  logic [15:0]     win_start = 16'h8000;
  logic [15:0]     win_end = 16'hC000;
  logic [PA_W-1:0] virt_base = '0;
  logic [4:0]      bank_shift = 5'd0;

  logic [PA_W-1:0] phys_n, phys_w;
  logic [3:0]      sel_n, sel_w;
  logic            miss_n, miss_w, ov_n, ov_w;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  banked_window_xlate u_dut (
    .clk(clk), .rst(rst), .reloc_we(reloc_we), .reloc_wdata(reloc_wdata),
    .req_valid(req_valid), .log_addr(log_addr), .page(page),
    .win_start(win_start), .win_end(win_end), .virt_base(virt_base),
    .bank_shift(bank_shift), .phys_addr(phys_n), .region_sel(sel_n),
    .miss(miss_n), .out_valid(ov_n)
  );

  banked_window_xlate #(.IO_WIDE(1'b1)) u_dut_wide (
    .clk(clk), .rst(rst), .reloc_we(reloc_we), .reloc_wdata(reloc_wdata),
    .req_valid(req_valid), .log_addr(log_addr), .page(page),
    .win_start(win_start), .win_end(win_end), .virt_base(virt_base),
    .bank_shift(bank_shift), .phys_addr(phys_w), .region_sel(sel_w),
    .miss(miss_w), .out_valid(ov_w)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Present one access (optionally with a relocation write in the same
  // cycle), then sample one cycle later, after the capturing edge.
  task automatic access(input logic [15:0] a, input logic wr, input logic [7:0] wd);
    @(negedge clk);
    log_addr    = a;
    req_valid   = 1'b1;
    reloc_we    = wr;
    reloc_wdata = wd;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    reloc_we  = 1'b0;
  endtask

  task automatic region_case(input string tag, input logic [15:0] a,
                             input logic [3:0] exp_n, input logic [3:0] exp_w);
    access(a, 1'b0, 8'h00);
    check({tag, " narrow sel"}, 32'(sel_n), 32'(exp_n));
    check({tag, " narrow miss"}, 32'(miss_n), 32'(exp_n == S_NONE));
    check({tag, " wide sel"}, 32'(sel_w), 32'(exp_w));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R11 out_valid", 32'(ov_n), 32'd0);
    check("R11 phys", 32'(phys_n), 32'd0);
    check("R11 sel", 32'(sel_n), 32'd0);
    check("R11 miss", 32'(miss_n), 32'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_window;
    win_start = 16'h8000; win_end = 16'hC000;
    page = 8'h03; bank_shift = 5'd14; virt_base = 24'h100000;
    access(16'h8000, 1'b0, 8'h00);
    check("R2 start inside", 32'(phys_n), 32'h10C000);
    check("R10 out_valid", 32'(ov_n), 32'd1);
    access(16'hBFFF, 1'b0, 8'h00);
    check("R1 last in window", 32'(phys_n), 32'h10FFFF);
    access(16'hC000, 1'b0, 8'h00);
    check("R2 end outside", 32'(phys_n), 32'h00C000);
    access(16'h7FFF, 1'b0, 8'h00);
    check("R3 below window", 32'(phys_n), 32'h007FFF);
    page = 8'h15; bank_shift = 5'd12; virt_base = 24'h000000;
    access(16'h8123, 1'b0, 8'h00);
    check("R1 page shift 12", 32'(phys_n), 32'h015123);
    page = 8'h10; virt_base = 24'hFFF000;
    access(16'h8000, 1'b0, 8'h00);
    check("R1 truncation", 32'(phys_n), 32'h00F000);
  endtask

  task automatic t_idle;
    access(16'h9000, 1'b0, 8'h00);
    @(posedge clk);
    #1;
    check("R10 idle valid low", 32'(ov_n), 32'd0);
    check("R10 idle phys hold", 32'(phys_n), 32'h00F000 + 32'h1000);
    check("R8 idle miss low", 32'(miss_n), 32'd0);
  endtask

  task automatic t_reset_map;
    // reloc = 0x01: I/O at 0x1000, NVRAM at 0x0000.
    region_case("R9 R5 io at reset base", 16'h1000, S_IO, S_IO);
    region_case("R5 io last narrow", 16'h103F, S_IO, S_IO);
    region_case("R5 io past narrow", 16'h1040, S_EXT, S_IO);
    region_case("R5 io last wide", 16'h13FF, S_EXT, S_IO);
    region_case("R5 io past wide", 16'h1400, S_EXT, S_EXT);
    region_case("R6 R4 nvram over ext", 16'h0010, S_NVR, S_NVR);
    region_case("R6 nvram end", 16'h0100, S_EXT, S_EXT);
    region_case("R7 eeprom first", 16'hF000, S_EEP, S_EEP);
    region_case("R7 eeprom last", 16'hF7FF, S_EEP, S_EEP);
    region_case("R8 past eeprom", 16'hF800, S_NONE, S_NONE);
    region_case("R8 hole", 16'h9000, S_NONE, S_NONE);
    region_case("R7 ext last", 16'h7FFF, S_EXT, S_EXT);
  endtask

  task automatic t_reloc;
    // Write 0x0F in the same cycle as an access to 0xF000: old map applies.
    access(16'hF000, 1'b1, 8'h0F);
    check("R9 same-cycle write uses old", 32'(sel_n), 32'(S_EEP));
    region_case("R9 R4 io over eeprom", 16'hF000, S_IO, S_IO);
    region_case("R4 eeprom past io", 16'hF040, S_EEP, S_IO);
    region_case("R9 old io base released", 16'h1000, S_EXT, S_EXT);
    region_case("R6 nvram at zero", 16'h0000, S_NVR, S_NVR);
    access(16'h0000, 1'b1, 8'h00);
    region_case("R4 io over nvram", 16'h0020, S_IO, S_IO);
    region_case("R4 nvram past io", 16'h0040, S_NVR, S_IO);
    access(16'h0000, 1'b1, 8'h50);
    region_case("R6 nvram relocated", 16'h0500, S_NVR, S_NVR);
    region_case("R6 nvram relocated end", 16'h0600, S_EXT, S_EXT);
  endtask

  initial begin
    t_reset;
    t_window;
    t_idle;
    t_reset_map;
    t_reloc;
    t_reset;
    region_case("R9 reset value restored", 16'h1000, S_IO, S_IO);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule